// File: doc/BRIEF.md
# Serpentine Window Readout Sequencer

This block produces the read addresses used to pull a stored picture out of a four-bank image memory while the display draws it. The picture is scanned inside a rectangular window. The row counter sweeps up and down between a bottom and a top row limit. The column counter only moves forward, one fetch column at a time. Every read enables all four banks together, so each fetch returns four 3-bit bins (12 bits).

The display controller loads the window limits and pulses a start input. The sequencer then issues one fetch per clock along a serpentine path. It starts at column 0 on the bottom row and climbs first. Each time the row counter reaches the limit it is heading for, the next fetch moves to the next column on that same row, and the sweep then turns back. While the last column is being read, an active-low column-limit flag is driven. When the last fetch has been issued, an active-low completion strobe pulses for one clock and the sequencer idles.

The memory answers one clock after the address. The block passes that word through with a valid flag aligned to it.

Top module: `mscan_seq`

## Requirements
- R1: While reset is held and after it is released with no start, rdEn and pixValid are 0, and xLimitN and scanDoneN are 1.
- R2: A startPulse seen while idle makes the next clock issue the first fetch at rdCol = 0 and rdRow = winYLo, with the row counter moving upward. The window must satisfy winYLo <= winYHi.
- R3: During a scan, rdEn stays 1 on every clock. Within one column, each fetch moves rdRow by exactly one toward the current limit.
- R4: After the fetch at the row limit the sweep is heading for, the next fetch uses rdCol + 1 on the same rdRow, and the sweep direction then reverses. rdCol never decreases.
- R5: xLimitN is 0 exactly on those clocks where a fetch is issued with rdCol equal to winXHi. It is 1 at all other times.
- R6: The scan ends with the fetch at column winXHi on the row limit the sweep is heading for (winYHi if winXHi is even, winYLo if odd). On the next clock rdEn is 0 and scanDoneN is 0 for exactly one clock. After that the block stays idle.
- R7: When winYLo equals winYHi, rdRow stays fixed and rdCol advances on every fetch, giving winXHi + 1 fetches.
- R8: pixValid is 1 exactly one clock after each fetch, and pixData then equals memData. Bin k occupies bits [3k+2:3k].
- R9: Limits are sampled only when a start is accepted. A startPulse or a change on winYLo, winYHi or winXHi during a scan does not alter the address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Starts a scan when idle |
| winYLo | input | 8 | Bottom row limit of the window |
| winYHi | input | 8 | Top row limit of the window |
| winXHi | input | 6 | Last fetch column of the window |
| rdRow | output | 8 | Row address to all banks |
| rdCol | output | 6 | Fetch column address to all banks |
| rdEn | output | 1 | Read enable, common to all banks |
| memData | input | 12 | Four 3-bit bins returned by the memory |
| pixData | output | 12 | Bins passed on to the display path |
| pixValid | output | 1 | pixData is valid |
| xLimitN | output | 1 | Low while the last column is fetched |
| scanDoneN | output | 1 | One-clock low pulse when the scan is complete |

## Verification
The bench targets the turn at each row limit. A design that turns one clock late re-reads a row or overshoots the window, and one that turns early skips the corner pixel of the next column. It runs windows with even and odd last columns, which differ in their terminating row, so a wrong stop condition either cuts the final column short or runs past it. A single-row window checks that the direction flip does not stall the column counter, and a single-column window checks the end strobe right after one sweep. Start pulses and limit changes during a scan would corrupt a design that re-samples its limits. The data check catches a valid flag shifted by one clock.

// File: rtl/mscan_pkg.sv
package mscan_pkg;
  typedef struct packed {
    logic load;   // capture limits and home the counters
    logic stepY;  // move row one step in current direction
    logic stepX;  // advance column and reverse row direction
  } mscan_ctl_t;
endpackage

// File: rtl/mscan_datapath.sv
module mscan_datapath
  import mscan_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int COL_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  mscan_ctl_t       ctl,
  input  logic [ROW_W-1:0] winYLo,
  input  logic [ROW_W-1:0] winYHi,
  input  logic [COL_W-1:0] winXHi,
  output logic [ROW_W-1:0] rowCnt,
  output logic [COL_W-1:0] colCnt,
  output logic             yAtLim,
  output logic             xAtEnd
);
  logic [ROW_W-1:0] loReg, hiReg;
  logic [COL_W-1:0] xEndReg;
  logic             upDir;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loReg   <= '0;
      hiReg   <= '0;
      xEndReg <= '0;
      rowCnt  <= '0;
      colCnt  <= '0;
      upDir   <= 1'b1;
    end else if (ctl.load) begin
      loReg   <= winYLo;
      hiReg   <= winYHi;
      xEndReg <= winXHi;
      rowCnt  <= winYLo;
      colCnt  <= '0;
      upDir   <= 1'b1;
    end else if (ctl.stepX) begin
      colCnt <= colCnt + 1'b1;
      upDir  <= ~upDir;
    end else if (ctl.stepY) begin
      if (upDir) rowCnt <= rowCnt + 1'b1;
      else       rowCnt <= rowCnt - 1'b1;
    end
  end

  // Row comparator looks at the limit the sweep is heading for
  always_comb yAtLim = upDir ? (rowCnt == hiReg) : (rowCnt == loReg);
  // Column comparator against the right-hand limit
  always_comb xAtEnd = (colCnt == xEndReg);
endmodule

// File: rtl/mscan_control.sv
module mscan_control
  import mscan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       yAtLim,
  input  logic       xAtEnd,
  output mscan_ctl_t ctl,
  output logic       scanning,
  output logic       doneN
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanning <= 1'b0;
      doneN    <= 1'b1;
    end else begin
      doneN <= 1'b1;
      if (!scanning) begin
        if (startPulse) scanning <= 1'b1;
      end else if (yAtLim && xAtEnd) begin
        scanning <= 1'b0;
        doneN    <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl.load  = !scanning && startPulse;
    ctl.stepX = scanning && yAtLim && !xAtEnd;
    ctl.stepY = scanning && !yAtLim;
  end
endmodule

// File: rtl/mscan_seq.sv
module mscan_seq
  import mscan_pkg::*;
#(
  parameter int ROW_W   = 8,
  parameter int PIX_X_W = 8,
  parameter int BINS    = 4,
  parameter int BIN_W   = 3,
  localparam int COL_W  = PIX_X_W - $clog2(BINS),
  localparam int DATA_W = BINS * BIN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [ROW_W-1:0]  winYLo,
  input  logic [ROW_W-1:0]  winYHi,
  input  logic [COL_W-1:0]  winXHi,
  output logic [ROW_W-1:0]  rdRow,
  output logic [COL_W-1:0]  rdCol,
  output logic              rdEn,
  input  logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] pixData,
  output logic              pixValid,
  output logic              xLimitN,
  output logic              scanDoneN
);
  mscan_ctl_t ctl;
  logic yAtLim, xAtEnd, scanning;

  mscan_control u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .yAtLim(yAtLim), .xAtEnd(xAtEnd),
    .ctl(ctl), .scanning(scanning), .doneN(scanDoneN)
  );

  mscan_datapath #(.ROW_W(ROW_W), .COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .winYLo(winYLo), .winYHi(winYHi), .winXHi(winXHi),
    .rowCnt(rdRow), .colCnt(rdCol),
    .yAtLim(yAtLim), .xAtEnd(xAtEnd)
  );

  always_comb rdEn    = scanning;
  always_comb xLimitN = !(scanning && xAtEnd);

  always_ff @(posedge clk) begin
    if (!rstN) pixValid <= 1'b0;
    else       pixValid <= scanning;
  end

  // Bins pass straight through; each lane is one bin of the fetch
  for (genvar k = 0; k < BINS; k++) begin : g_bin
    always_comb pixData[k*BIN_W +: BIN_W] = memData[k*BIN_W +: BIN_W];
  end
endmodule

// File: rtl/mscan_seq_chk.sv
module mscan_seq_chk #(
  parameter int ROW_W = 8,
  parameter int COL_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             rdEn,
  input logic [ROW_W-1:0] rdRow,
  input logic [COL_W-1:0] rdCol,
  input logic             pixValid,
  input logic             xLimitN,
  input logic             scanDoneN
);
  p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> pixValid);
  p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !pixValid);
  p_xlim_in_fetch_r5: assert property (@(posedge clk) disable iff (!rstN)
    !xLimitN |-> rdEn);
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    !scanDoneN |=> scanDoneN);
  p_done_after_fetch_r6: assert property (@(posedge clk) disable iff (!rstN)
    !scanDoneN |-> (!rdEn && $past(rdEn) && !$past(xLimitN)));
  p_col_forward_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && $past(rdEn)) |->
      (rdCol == $past(rdCol)) || (rdCol == COL_W'($past(rdCol) + 1'b1)));
  p_row_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && $past(rdEn) && rdCol == $past(rdCol)) |->
      (rdRow == ROW_W'($past(rdRow) + 1'b1)) || (rdRow == ROW_W'($past(rdRow) - 1'b1)));
  p_turn_same_row_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && $past(rdEn) && rdCol != $past(rdCol)) |-> $stable(rdRow));
endmodule

bind mscan_seq mscan_seq_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdRow(rdRow), .rdCol(rdCol),
  .pixValid(pixValid), .xLimitN(xLimitN), .scanDoneN(scanDoneN)
);

// File: tb/sim_mscan_seq.sv
module sim_mscan_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [7:0] winYLo = '0, winYHi = '0;
  logic [5:0] winXHi = '0;
  logic [7:0] rdRow;
  logic [5:0] rdCol;
  logic rdEn, pixValid, xLimitN, scanDoneN;
  logic [11:0] memData = '0;
  logic [11:0] pixData;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  mscan_seq u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .winYLo(winYLo), .winYHi(winYHi), .winXHi(winXHi),
    .rdRow(rdRow), .rdCol(rdCol), .rdEn(rdEn),
    .memData(memData), .pixData(pixData), .pixValid(pixValid),
    .xLimitN(xLimitN), .scanDoneN(scanDoneN)
  );

  function automatic logic [11:0] memWord(input int row, input int col);
    return 12'({col[5:0], row[5:0]} ^ 12'hA5C) ^ 12'(row >> 6);
  endfunction

  // Memory model: one clock read latency
  always @(posedge clk) memData <= rdEn ? memWord(int'(rdRow), int'(rdCol)) : 12'h000;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic runScan(input int lo, input int hi, input int xh, input bit disturb, input string tag);
    int step = 0;
    int prevRow = 0, prevCol = 0;
    @(negedge clk);
    winYLo = 8'(lo); winYHi = 8'(hi); winXHi = 6'(xh);
    startPulse = 1'b1;
    for (int c = 0; c <= xh; c++) begin
      for (int k = 0; k <= hi - lo; k++) begin
        int er;
        er = (c % 2 == 0) ? lo + k : hi - k;
        @(negedge clk);
        startPulse = 1'b0;
        if (disturb && step == 2) begin
          // R9: start and limit changes during a scan
          startPulse = 1'b1;
          winYLo = 8'(lo + 1); winYHi = 8'(hi + 3); winXHi = 6'(xh + 2);
        end
        chk(rdEn == 1'b1, {tag, " R3 rdEn"}, int'(rdEn), 1);
        chk(int'(rdRow) == er, (step == 0) ? {tag, " R2 first row"} : {tag, " R3 row"}, int'(rdRow), er);
        chk(int'(rdCol) == c, (step == 0) ? {tag, " R2 first col"} : {tag, " R4 col"}, int'(rdCol), c);
        chk(xLimitN == !(c == xh), {tag, " R5 xLimitN"}, int'(xLimitN), int'(!(c == xh)));
        chk(scanDoneN == 1'b1, {tag, " R6 early done"}, int'(scanDoneN), 1);
        if (step == 0) chk(pixValid == 1'b0, {tag, " R8 valid"}, int'(pixValid), 0);
        else begin
          chk(pixValid == 1'b1, {tag, " R8 valid"}, int'(pixValid), 1);
          chk(pixData == memWord(prevRow, prevCol), {tag, " R8 data"}, int'(pixData), int'(memWord(prevRow, prevCol)));
        end
        prevRow = er; prevCol = c; step++;
      end
    end
    @(negedge clk);
    startPulse = 1'b0;
    chk(rdEn == 1'b0, {tag, " R6 stop"}, int'(rdEn), 0);
    chk(scanDoneN == 1'b0, {tag, " R6 done low"}, int'(scanDoneN), 0);
    chk(xLimitN == 1'b1, {tag, " R5 idle"}, int'(xLimitN), 1);
    chk(pixValid == 1'b1, {tag, " R8 last valid"}, int'(pixValid), 1);
    chk(pixData == memWord(prevRow, prevCol), {tag, " R8 last data"}, int'(pixData), int'(memWord(prevRow, prevCol)));
    @(negedge clk);
    chk(scanDoneN == 1'b1, {tag, " R6 one clock"}, int'(scanDoneN), 1);
    chk(rdEn == 1'b0, {tag, " R6 idle"}, int'(rdEn), 0);
    chk(pixValid == 1'b0, {tag, " R8 idle"}, int'(pixValid), 0);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk(rdEn == 1'b0, "R1 rdEn in reset", int'(rdEn), 0);
    chk(xLimitN == 1'b1, "R1 xLimitN in reset", int'(xLimitN), 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(rdEn == 1'b0, "R1 rdEn idle", int'(rdEn), 0);
    chk(pixValid == 1'b0, "R1 pixValid idle", int'(pixValid), 0);
    chk(scanDoneN == 1'b1, "R1 scanDoneN idle", int'(scanDoneN), 1);
    chk(xLimitN == 1'b1, "R1 xLimitN idle", int'(xLimitN), 1);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    runScan(3, 5, 2, 1'b0, "odd-cols");          // ends on top row
    runScan(10, 13, 1, 1'b0, "even-cols");       // ends on bottom row
    runScan(7, 7, 5, 1'b0, "R7 flat");           // single row window
    runScan(0, 4, 0, 1'b0, "single-col");
    runScan(20, 24, 3, 1'b1, "R9 disturb");
    runScan(0, 255, 63, 1'b0, "full");
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule